// File: doc/BRIEF.md
# Modem Handshake Control and Status Register Block

This block sits beside a serial port and handles the modem handshake lines. Software writes a small control register that drives four active-low handshake outputs. Software reads a status register that shows the present level of four active-low handshake inputs. The same register also holds a sticky change flag for each input. The change flags clear when the status register is read. When any flag is set and the modem interrupt is enabled, the block raises an interrupt request.

A loop input turns on a diagnostic mode. In this mode the four outputs are parked at their inactive level, and the control bits are fed back internally in place of the external inputs. Software can then make every status change and every change flag happen without any cable attached.

The external inputs are asynchronous. Each one passes through a multi-flop synchronizer before the edge detection. The CPU port uses one select bit: 0 selects the control register and 1 selects the status register. Read data is combinational from the registers.

Top module: `modem_ctl_stat`

## Requirements
- R1: While `rst` is high and after it falls (until the first write), `dtrN`, `rtsN`, `out1N` and `out2N` are high and `msIrq` is low. The control register reads 0x00. The status register reads 0x00 when all input pins are high.
- R2: A write with `regSel`=0 stores `wrData[3:0]`. Bit 0 controls `dtrN`, bit 1 `rtsN`, bit 2 `out1N` and bit 3 `out2N`. A stored 1 drives its pin low from the cycle after the write. Reading with `regSel`=0 returns the stored bits in [3:0] and zeros in [7:4].
- R3: Status bits [7:4] give the active-high state of `ctsN` (bit 4), `dsrN` (bit 5), `riN` (bit 6) and `dcdN` (bit 7). A low pin reads as 1. The bit follows a pin change after the synchronizer delay of two clock edges.
- R4: Status bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) set on any change of their input in either direction. Once set, they stay set until a status read.
- R5: Status bit 2 sets only when `riN` goes from low to high. A high-to-low change of `riN` leaves it clear.
- R6: A status read (`rdEn`=1, `regSel`=1) returns the flags as they were and clears all four flags at the following clock edge. A change detected in that same cycle is kept set.
- R7: While `loopEn` is high, all four control outputs are high whatever the control register holds. The control register keeps its value and still reads back.
- R8: While `loopEn` is high, the status state bits come from the control bits: RTS to CTS, DTR to DSR, OUT1 to RI, OUT2 to DCD. The external input pins have no effect, and change flags follow the looped values.
- R9: `msIrq` is high exactly when `msIntEn` is high and at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous master reset, active high |
| regSel | input | 1 | Register select: 0 control, 1 status |
| wrEn | input | 1 | Write strobe (only the control register is writable) |
| rdEn | input | 1 | Read strobe; a status read clears the change flags |
| wrData | input | 4 | Write data for the control register |
| rdData | output | 8 | Read data of the selected register |
| ctsN | input | 1 | Clear-to-send input, active low, asynchronous |
| dsrN | input | 1 | Data-set-ready input, active low, asynchronous |
| riN | input | 1 | Ring input, active low, asynchronous |
| dcdN | input | 1 | Carrier-detect input, active low, asynchronous |
| dtrN | output | 1 | Terminal-ready output, active low |
| rtsN | output | 1 | Request-to-send output, active low |
| out1N | output | 1 | General output 1, active low |
| out2N | output | 1 | General output 2, active low |
| loopEn | input | 1 | Diagnostic loop mode enable |
| msIntEn | input | 1 | Modem status interrupt enable |
| msIrq | output | 1 | Modem status interrupt request |

## Verification
The hardest case to reach from the ports is an input change that lands on the same clock edge as the read that clears the flags. The stimulus lowers `ctsN` and then counts exactly the two synchronizer edges. It issues the status read in the one cycle where the detected change and the clear strobe coincide. It then expects the state bit to show in that read and the flag to survive into the next read. The ring input gets only its falling edge first and only its rising edge after, so the one-direction rule is checked on its own. Random pin patterns with a random interrupt enable drive a bench-side model of the sticky flags. Loop mode is entered with the pins wiggling, to show that they are ignored.

// File: rtl/modem_pkg.sv
package modem_pkg;
  // Number of handshake lines in each direction
  localparam int NUM_LINES = 4;
  localparam int RD_W      = 2 * NUM_LINES;

  // Index of each status input inside the state/flag vectors
  localparam int ST_CTS = 0;
  localparam int ST_DSR = 1;
  localparam int ST_RI  = 2;
  localparam int ST_DCD = 3;

  // Index of each control bit inside the control register
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OUT1 = 2;
  localparam int CB_OUT2 = 3;

  // Strobes from the port decoder to the datapath
  typedef struct packed {
    logic wrCtrl;
    logic rdStat;
  } modemStrobe_t;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) begin
        stg[k] <= stg[k-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/modem_ctrl.sv
module modem_ctrl
  import modem_pkg::*;
(
  input  logic                 regSel,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [NUM_LINES-1:0] ctrlQ,
  input  logic [NUM_LINES-1:0] stateNow,
  input  logic [NUM_LINES-1:0] deltaQ,
  output modemStrobe_t         strb,
  output logic [RD_W-1:0]      rdData
);
  // Only the control register takes writes; only a status read clears flags
  always_comb begin
    strb.wrCtrl = wrEn & ~regSel;
    strb.rdStat = rdEn & regSel;
  end

  always_comb begin
    if (regSel) rdData = {stateNow, deltaQ};
    else        rdData = {{NUM_LINES{1'b0}}, ctrlQ};
  end
endmodule

// File: rtl/modem_dpath.sv
module modem_dpath
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  modemStrobe_t         strb,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [NUM_LINES-1:0] pinsN,     // index order: CTS, DSR, RI, DCD
  input  logic                 loopEn,
  input  logic                 msIntEn,
  output logic [NUM_LINES-1:0] ctrlQ,
  output logic [NUM_LINES-1:0] stateNow,
  output logic [NUM_LINES-1:0] deltaQ,
  output logic [NUM_LINES-1:0] evt,
  output logic [NUM_LINES-1:0] ctrlOutN,  // index order: DTR, RTS, OUT1, OUT2
  output logic                 msIrq
);
  logic [NUM_LINES-1:0] pinsSyncN;
  logic [NUM_LINES-1:0] loopState;
  logic [NUM_LINES-1:0] prevState;
  logic [NUM_LINES-1:0] deltaNext;

  modem_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NUM_LINES{1'b1}})
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pinsN),
    .dout(pinsSyncN)
  );

  // Control register
  always_ff @(posedge clk) begin
    if (rst)              ctrlQ <= '0;
    else if (strb.wrCtrl) ctrlQ <= wrData;
  end

  // Internal feedback path used in loop mode
  always_comb begin
    loopState         = '0;
    loopState[ST_CTS] = ctrlQ[CB_RTS];
    loopState[ST_DSR] = ctrlQ[CB_DTR];
    loopState[ST_RI]  = ctrlQ[CB_OUT1];
    loopState[ST_DCD] = ctrlQ[CB_OUT2];
  end

  assign stateNow = loopEn ? loopState : ~pinsSyncN;

  always_ff @(posedge clk) begin
    if (rst) prevState <= '0;
    else     prevState <= stateNow;
  end

  // Per-line change detection; ring reports only active-to-inactive
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_edge
    if (i == ST_RI) begin : g_trail
      assign evt[i] = prevState[i] & ~stateNow[i];
    end else begin : g_any
      assign evt[i] = prevState[i] ^ stateNow[i];
    end
  end

  // Sticky flags: a read clears, a same-cycle event wins over the clear
  always_comb begin
    deltaNext = (strb.rdStat ? '0 : deltaQ) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) deltaQ <= '0;
    else     deltaQ <= deltaNext;
  end

  assign ctrlOutN = loopEn ? '1 : ~ctrlQ;
  assign msIrq    = msIntEn & (|deltaQ);
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 regSel,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [NUM_LINES-1:0] wrData,
  output logic [RD_W-1:0]      rdData,
  input  logic                 ctsN,
  input  logic                 dsrN,
  input  logic                 riN,
  input  logic                 dcdN,
  output logic                 dtrN,
  output logic                 rtsN,
  output logic                 out1N,
  output logic                 out2N,
  input  logic                 loopEn,
  input  logic                 msIntEn,
  output logic                 msIrq
);
  modemStrobe_t         strb;
  logic [NUM_LINES-1:0] ctrlVec;
  logic [NUM_LINES-1:0] stateVec;
  logic [NUM_LINES-1:0] deltaVec;
  logic [NUM_LINES-1:0] evtVec;
  logic [NUM_LINES-1:0] outVecN;
  logic [NUM_LINES-1:0] pinVecN;

  assign pinVecN = {dcdN, riN, dsrN, ctsN};

  modem_ctrl u_ctrl (
    .regSel  (regSel),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .ctrlQ   (ctrlVec),
    .stateNow(stateVec),
    .deltaQ  (deltaVec),
    .strb    (strb),
    .rdData  (rdData)
  );

  modem_dpath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .wrData  (wrData),
    .pinsN   (pinVecN),
    .loopEn  (loopEn),
    .msIntEn (msIntEn),
    .ctrlQ   (ctrlVec),
    .stateNow(stateVec),
    .deltaQ  (deltaVec),
    .evt     (evtVec),
    .ctrlOutN(outVecN),
    .msIrq   (msIrq)
  );

  assign dtrN  = outVecN[CB_DTR];
  assign rtsN  = outVecN[CB_RTS];
  assign out1N = outVecN[CB_OUT1];
  assign out2N = outVecN[CB_OUT2];
endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk (
  input logic       clk,
  input logic       rst,
  input logic       regSel,
  input logic       wrEn,
  input logic       rdEn,
  input logic [3:0] wrData,
  input logic       loopEn,
  input logic       msIntEn,
  input logic       msIrq,
  input logic       dtrN,
  input logic       rtsN,
  input logic       out1N,
  input logic       out2N,
  input logic [3:0] deltaQ,
  input logic [3:0] evt
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (dtrN && rtsN && out1N && out2N && deltaQ == 4'h0 && !msIrq));

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !regSel && !loopEn) |=>
      (loopEn || {out2N, out1N, rtsN, dtrN} == ~$past(wrData)));

  assert_flag_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (evt != 4'h0) |=> ((deltaQ & $past(evt)) == $past(evt)));

  assert_flag_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!(rdEn && regSel) && evt == 4'h0) |=> $stable(deltaQ));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (rdEn && regSel && evt == 4'h0) |=> (deltaQ == 4'h0));

  assert_loop_parks_R7: assert property (@(posedge clk) disable iff (rst)
    loopEn |-> (dtrN && rtsN && out1N && out2N));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (!msIntEn || deltaQ == 4'h0) |-> !msIrq);

  assert_irq_raised_R9: assert property (@(posedge clk) disable iff (rst)
    (msIntEn && deltaQ != 4'h0) |-> msIrq);
endmodule

bind modem_ctl_stat modem_ctl_stat_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .regSel (regSel),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .wrData (wrData),
  .loopEn (loopEn),
  .msIntEn(msIntEn),
  .msIrq  (msIrq),
  .dtrN   (dtrN),
  .rtsN   (rtsN),
  .out1N  (out1N),
  .out2N  (out2N),
  .deltaQ (deltaVec),
  .evt    (evtVec)
);

// File: tb/tb_modem_ctl_stat.sv
module tb_modem_ctl_stat;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       regSel = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [3:0] wrData = 4'h0;
  logic [7:0] rdData;
  logic       ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic       dtrN, rtsN, out1N, out2N;
  logic       loopEn = 1'b0;
  logic       msIntEn = 1'b0;
  logic       msIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  modem_ctl_stat dut (
    .clk(clk), .rst(rst), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData),
    .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN),
    .dtrN(dtrN), .rtsN(rtsN), .out1N(out1N), .out2N(out2N),
    .loopEn(loopEn), .msIntEn(msIntEn), .msIrq(msIrq)
  );

  // Pin vector order: [0]=CTS [1]=DSR [2]=RI [3]=DCD, active low
  logic [3:0] pinsN = 4'hF;
  logic [3:0] expDelta = 4'h0;

  function automatic logic [3:0] flagEvents(logic [3:0] oldSt, logic [3:0] newSt);
    return ((oldSt ^ newSt) & 4'b1011) | (oldSt & ~newSt & 4'b0100);
  endfunction

  // Control bits (DTR,RTS,OUT1,OUT2) to looped state (CTS,DSR,RI,DCD)
  function automatic logic [3:0] loopMap(logic [3:0] c);
    return {c[3], c[2], c[0], c[1]};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic applyPins(logic [3:0] p);
    @(negedge clk);
    {dcdN, riN, dsrN, ctsN} = p;
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCtrl(logic [3:0] v);
    @(negedge clk);
    regSel = 1'b0; wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(logic sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic logic [7:0] outsN();
    return {4'h0, out2N, out1N, rtsN, dtrN};
  endfunction

  // Move pins, let synchronizer settle, and track expected flags
  task automatic stepPins(logic [3:0] p);
    logic [3:0] oldSt;
    oldSt = ~pinsN;
    applyPins(p);
    pinsN = p;
    waitCycles(4);
    expDelta = expDelta | flagEvents(oldSt, ~p);
  endtask

  initial begin
    logic [7:0] d;
    logic [3:0] v;
    int seedDummy;
    seedDummy = $urandom(32'd20240611);

    // R1: reset state
    waitCycles(5);
    check("R1 outputs during reset", outsN(), 8'h0F);
    rst = 1'b0;
    #1 check("R1 irq after reset", {7'h0, msIrq}, 8'h00);
    readReg(1'b0, d); check("R1 control readback", d, 8'h00);
    readReg(1'b1, d); check("R1 status readback", d, 8'h00);
    check("R1 outputs after reset", outsN(), 8'h0F);

    // R2: control writes
    for (int i = 0; i < 6; i++) begin
      v = (i == 0) ? 4'hF : (i == 1) ? 4'h0 : 4'($urandom_range(0, 15));
      writeCtrl(v);
      #1 check("R2 output pins", outsN(), {4'h0, ~v});
      readReg(1'b0, d);
      check("R2 control readback", d, {4'h0, v});
    end
    writeCtrl(4'h0);

    // R5: ring falling pin edge alone does not flag, rising does
    stepPins(4'b1011);
    readReg(1'b1, d);
    check("R5 ring high-to-low no flag", d, 8'h40);
    expDelta = 4'h0;
    stepPins(4'b1111);
    readReg(1'b1, d);
    check("R5 ring low-to-high flags", d, 8'h04);
    expDelta = 4'h0;

    // R4: CTS both directions
    stepPins(4'b1110);
    readReg(1'b1, d); check("R4 cts fall flags", d, 8'h11);
    expDelta = 4'h0;
    stepPins(4'b1111);
    readReg(1'b1, d); check("R4 cts rise flags", d, 8'h01);
    expDelta = 4'h0;
    readReg(1'b1, d); check("R6 flags cleared by read", d, 8'h00);

    // R6: change detected in the same cycle as the clearing read
    @(negedge clk); ctsN = 1'b0; pinsN = 4'b1110;
    @(posedge clk); @(posedge clk);
    @(negedge clk); regSel = 1'b1; rdEn = 1'b1;
    #1 d = rdData;
    check("R6 read during event shows old flags", d, 8'h10);
    @(negedge clk); rdEn = 1'b0;
    readReg(1'b1, d);
    check("R6 event survives clearing read", d, 8'h11);
    expDelta = 4'h0;

    // R3/R4/R5/R9: random pin activity with a bench-side flag model
    for (int i = 0; i < 60; i++) begin
      stepPins(4'($urandom_range(0, 15)));
      @(negedge clk); msIntEn = 1'($urandom_range(0, 1));
      #1 check("R9 irq vs enable and flags", {7'h0, msIrq},
               {7'h0, msIntEn && (expDelta != 4'h0)});
      if ($urandom_range(0, 2) == 0) begin
        readReg(1'b1, d);
        check("R3 R4 R5 status state and flags", d, {~pinsN, expDelta});
        expDelta = 4'h0;
      end
    end
    stepPins(4'hF);
    readReg(1'b1, d);
    check("R3 status after return to idle", d, {4'h0, expDelta});
    expDelta = 4'h0;
    msIntEn = 1'b1;

    // R7/R8: loop mode with pins wiggling
    writeCtrl(4'h0);
    @(negedge clk); loopEn = 1'b1;
    applyPins(4'b0101);
    waitCycles(4);
    readReg(1'b1, d);
    check("R8 external pins ignored in loop", d, 8'h00);
    v = 4'b1101;
    writeCtrl(v);
    #1 check("R7 outputs parked in loop", outsN(), 8'h0F);
    readReg(1'b0, d);
    check("R7 control retained in loop", d, {4'h0, v});
    #1 check("R9 irq from looped change", {7'h0, msIrq}, 8'h01);
    readReg(1'b1, d);
    check("R8 looped state and flags", d, {loopMap(v), loopMap(v) & 4'b1011});
    applyPins(4'b0000);
    writeCtrl(4'h0);
    waitCycles(2);
    readReg(1'b1, d);
    check("R8 looped return flags incl ring", d, {4'h0, loopMap(v)});
    applyPins(4'hF);
    pinsN = 4'hF;
    waitCycles(4);
    @(negedge clk); loopEn = 1'b0;
    waitCycles(2);
    readReg(1'b1, d);
    check("R8 leaving loop with idle pins", d, 8'h00);
    writeCtrl(4'b0110);
    #1 check("R7 outputs restored after loop", outsN(), 8'h09);

    finish();
  end

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end
endmodule